// File: doc/BRIEF.md
# CEC Transmit Frame Sequencer

This block sends one HDMI-CEC frame of 1 to 16 bytes over a single-wire, wired-AND bus. Software loads the bytes into a small buffer through a valid/ready write port, then issues one control write that carries the byte count, a launch bit and two automation options. The sequencer waits until the bus has been free for a chosen number of bit periods. It then optionally sends the start bit, and shifts out every byte MSB first. Each byte is followed by its end-of-message bit and an acknowledge slot.

While it transmits, the block reads the line back. A 1 that is overridden inside the first (header) byte means arbitration was lost. The same override in a later byte is reported as a transmit error. A high line in the acknowledge slot is a missing acknowledge. Completion is reported through a set of status flags. All timing uses a base unit of 50 µs, which is `UNIT_DIV` clock cycles. A bit period is 48 units (2.4 ms).

Write port rules: a byte is stored on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole of a frame. A writer that sees `wr_ready` low must hold its byte and retry; a byte offered while `wr_ready` is low is not stored.

Top module: `cec_tx_seq`

## Requirements
- R1: A buffer write is stored only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low while a frame is in progress, and a byte offered then leaves the buffer unchanged.
- R2: A control write with `ctl_data[5]`=1 launches a frame whose byte count is `ctl_data[4:0]`. It is ignored while busy. A count of 0 or above 16 sets `done` and `tx_err` in the next cycle, and the line is never driven.
- R3: Before the first bit, the line must be seen high on that many consecutive units: `sft_sel` 0 gives 3 bit periods, 1 gives 5, and 2 or 3 give 7. A low line restarts the count.
- R4: With `ctl_data[6]`=1 a start bit is sent first: low for 74 units within 90. With it 0, the first data bit follows the idle wait directly.
- R5: Data bits go out MSB first. A 0 is low for 30 of 48 units and a 1 is low for 12 of 48 units, and bits follow each other with no gap.
- R6: The ninth bit of each byte is end-of-message. With `ctl_data[7]`=1 it is 1 on the last byte and 0 on the others; with `ctl_data[7]`=0 it is always 0.
- R7: The tenth bit of each byte is an acknowledge slot driven as a 1. The line is sampled at unit 21 of that bit, and a low sample counts as acknowledged.
- R8: With `stop_on_nack`=1, the frame ends at the sampling point of the first unacknowledged byte. Without it, the frame runs to the end.
- R9: If the line is sampled low at unit 21 while a 1 is being sent in the header byte (data or end-of-message bit), the block releases the line and ends with `arb_lost`.
- R10: The same conflict in any later byte ends the frame with `tx_err`.
- R11: `done` rises in the cycle after the last bit ends, or after the aborting sample. `ack_ok` is set only if every byte was acknowledged and the frame completed. All flags clear when a frame is accepted.
- R12: The time unit is `UNIT_DIV` cycles, counted from the launching control write. A frame's waveform is therefore the same in every cycle, whatever happened before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Buffer byte offered |
| wr_ready | output | 1 | Buffer accepts bytes (idle) |
| wr_addr | input | 4 | Buffer byte offset |
| wr_data | input | 8 | Buffer byte |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | [4:0] count, [5] launch, [6] auto start, [7] auto end-of-message |
| sft_sel | input | 2 | Bus-free wait select |
| stop_on_nack | input | 1 | End frame at first missing acknowledge |
| line_in | input | 1 | Wired-AND bus level |
| drive_low | output | 1 | Pull the bus low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame finished |
| ack_ok | output | 1 | All bytes acknowledged |
| tx_err | output | 1 | Bad count or later-byte conflict |
| arb_lost | output | 1 | Header conflict |

## Verification
The bench's model is anchored to the clock edge that accepts the control write. The model lists the expected `drive_low` level for every following cycle. That list has the idle wait first, then each bit as a whole number of units times `UNIT_DIV`. An aborted bit is cut off after unit 21. The bench compares the list cycle by cycle and expects `done` low all along. `done` and the other flags are checked in the first cycle after the list ends, or in the cycle right after the control write when the count is invalid. Acknowledges and conflicts from the far end are entered into the same per-cycle schedule, so each one lands at a known bit and unit.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;
  typedef enum logic [1:0] {BK_START, BK_ZERO, BK_ONE} bit_kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BITS} tx_state_t;

  // timing in 50 us units
  localparam int unsigned BIT_U       = 48;
  localparam int unsigned ZERO_LOW_U  = 30;
  localparam int unsigned ONE_LOW_U   = 12;
  localparam int unsigned START_U     = 90;
  localparam int unsigned START_LOW_U = 74;
  localparam int unsigned SAMPLE_U    = 21;

  // bus-free wait lengths in bit periods
  localparam int unsigned SFT_RETRY   = 3;
  localparam int unsigned SFT_NEW     = 5;
  localparam int unsigned SFT_PRESENT = 7;

  // control word layout
  localparam int unsigned LEN_W      = 5;
  localparam int unsigned CTL_GO_B   = 5;
  localparam int unsigned CTL_SOM_B  = 6;
  localparam int unsigned CTL_EOM_B  = 7;
  localparam int unsigned ACK_SLOT   = 9;
  localparam int unsigned EOM_SLOT   = 8;
endpackage

// File: rtl/cec_unit_tick.sv
module cec_unit_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] pcnt;

  assign tick = (pcnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             pcnt <= '0;
    else if (clr || tick)   pcnt <= '0;
    else                    pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/cec_tx_buffer.sv
module cec_tx_buffer #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                slot[g] <= '0;
      else if (wr_en && wr_addr == AW'(g))       slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_addr];
endmodule

// File: rtl/cec_bit_shaper.sv
module cec_bit_shaper
  import cec_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      go,
  input  logic      abort,
  input  bit_kind_t kind,
  output logic      drive_low,
  output logic      sample_stb,
  output logic      bit_end
);
  localparam int unsigned CNT_W = $clog2(START_U + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  bit_kind_t        kind_r;
  logic [CNT_W-1:0] low_len, period;

  always_comb begin
    unique case (kind_r)
      BK_START: begin low_len = CNT_W'(START_LOW_U); period = CNT_W'(START_U); end
      BK_ZERO:  begin low_len = CNT_W'(ZERO_LOW_U);  period = CNT_W'(BIT_U);   end
      default:  begin low_len = CNT_W'(ONE_LOW_U);   period = CNT_W'(BIT_U);   end
    endcase
  end

  assign drive_low  = active && (cnt < low_len);
  assign sample_stb = active && tick && (cnt == CNT_W'(SAMPLE_U));
  assign bit_end    = active && tick && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      kind_r <= BK_ONE;
    end else if (abort) begin
      active <= 1'b0;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
      kind_r <= kind;
    end else if (active && tick) begin
      if (cnt == period - 1'b1) active <= 1'b0;
      else                      cnt    <= cnt + 1'b1;
    end
  end

  // R5
  go_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!active || bit_end));
  // R7
  stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_end));
endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq
  import cec_tx_pkg::*;
#(
  parameter int unsigned UNIT_DIV = 2,
  parameter int unsigned DEPTH    = 16,
  localparam int unsigned AW      = $clog2(DEPTH),
  localparam int unsigned NEED_W  = $clog2(SFT_PRESENT * BIT_U + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_data,
  input  logic [1:0]    sft_sel,
  input  logic          stop_on_nack,
  input  logic          line_in,
  output logic          drive_low,
  output logic          busy,
  output logic          done,
  output logic          ack_ok,
  output logic          tx_err,
  output logic          arb_lost
);
  tx_state_t          state;
  logic [LEN_W-1:0]   len_r;
  logic               som_r, eom_r, stop_r;
  logic [NEED_W-1:0]  need_r, icnt;
  logic [AW-1:0]      byte_idx;
  logic [3:0]         bit_idx;
  logic               cur_start, cur_val, ack_all;

  logic               tick, sample_stb, bit_end;
  logic [7:0]         rd_data;
  logic [AW-1:0]      nb;
  logic [3:0]         nbit;
  logic               launch, nstart, nval, finish;
  logic               samp, conflict, nack, abort_now;
  logic               last_byte, nb_last;
  bit_kind_t          nkind;
  logic [LEN_W-1:0]   req_len;
  logic               req_ok;
  logic [NEED_W-1:0]  req_need;
  logic [2:0]         bsel;

  assign wr_ready = (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);

  cec_unit_tick #(.DIV(UNIT_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .tick(tick));

  cec_tx_buffer #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(nb), .rd_data(rd_data));

  cec_bit_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(launch), .abort(abort_now),
    .kind(nkind), .drive_low(drive_low), .sample_stb(sample_stb), .bit_end(bit_end));

  // control word decode
  assign req_len = ctl_data[LEN_W-1:0];
  assign req_ok  = (req_len != '0) && (req_len <= LEN_W'(DEPTH));
  always_comb begin
    unique case (sft_sel)
      2'd0:    req_need = NEED_W'(SFT_RETRY * BIT_U);
      2'd1:    req_need = NEED_W'(SFT_NEW * BIT_U);
      default: req_need = NEED_W'(SFT_PRESENT * BIT_U);
    endcase
  end

  assign last_byte = (LEN_W'(byte_idx) == len_r - 1'b1);

  // next-bit selection
  always_comb begin
    launch = 1'b0;
    nstart = 1'b0;
    finish = 1'b0;
    nb     = byte_idx;
    nbit   = bit_idx;
    if (state == ST_WAIT) begin
      if (tick && line_in && icnt == need_r - 1'b1) begin
        launch = 1'b1;
        nstart = som_r;
        nb     = '0;
        nbit   = '0;
      end
    end else if (state == ST_BITS && bit_end) begin
      if (cur_start) begin
        launch = 1'b1;
        nb     = '0;
        nbit   = '0;
      end else if (bit_idx == 4'(ACK_SLOT)) begin
        if (last_byte) finish = 1'b1;
        else begin
          launch = 1'b1;
          nb     = byte_idx + 1'b1;
          nbit   = '0;
        end
      end else begin
        launch = 1'b1;
        nbit   = bit_idx + 1'b1;
      end
    end
  end

  assign nb_last = (LEN_W'(nb) == len_r - 1'b1);
  assign bsel    = 3'd7 - nbit[2:0];
  always_comb begin
    if (nbit < 4'(EOM_SLOT))       nval = rd_data[bsel];
    else if (nbit == 4'(EOM_SLOT)) nval = eom_r && nb_last;
    else                           nval = 1'b1;
  end
  assign nkind = nstart ? BK_START : (nval ? BK_ONE : BK_ZERO);

  // line monitoring
  assign samp      = (state == ST_BITS) && sample_stb && !cur_start;
  assign conflict  = samp && cur_val && !line_in && (bit_idx != 4'(ACK_SLOT));
  assign nack      = samp && (bit_idx == 4'(ACK_SLOT)) && line_in;
  assign abort_now = conflict || (nack && stop_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      len_r     <= '0;
      som_r     <= 1'b0;
      eom_r     <= 1'b0;
      stop_r    <= 1'b0;
      need_r    <= '0;
      icnt      <= '0;
      byte_idx  <= '0;
      bit_idx   <= '0;
      cur_start <= 1'b0;
      cur_val   <= 1'b0;
      ack_all   <= 1'b0;
      done      <= 1'b0;
      ack_ok    <= 1'b0;
      tx_err    <= 1'b0;
      arb_lost  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ctl_wr && ctl_data[CTL_GO_B]) begin
            ack_ok   <= 1'b0;
            arb_lost <= 1'b0;
            if (req_ok) begin
              state   <= ST_WAIT;
              done    <= 1'b0;
              tx_err  <= 1'b0;
              len_r   <= req_len;
              som_r   <= ctl_data[CTL_SOM_B];
              eom_r   <= ctl_data[CTL_EOM_B];
              stop_r  <= stop_on_nack;
              need_r  <= req_need;
              icnt    <= '0;
              ack_all <= 1'b1;
            end else begin
              done    <= 1'b1;
              tx_err  <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tick) begin
            if (!line_in)    icnt  <= '0;
            else if (launch) state <= ST_BITS;
            else             icnt  <= icnt + 1'b1;
          end
        end
        default: begin
          if (abort_now) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (conflict) begin
              if (byte_idx == '0) arb_lost <= 1'b1;
              else                tx_err   <= 1'b1;
            end
          end else if (nack) begin
            ack_all <= 1'b0;
          end
          if (finish) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            ack_ok <= ack_all;
          end
        end
      endcase
      if (launch) begin
        byte_idx  <= nb;
        bit_idx   <= nbit;
        cur_start <= nstart;
        cur_val   <= nval;
      end
    end
  end

  // R11
  ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |-> done);
  // R9
  arb_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> ($past(byte_idx) == '0));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_err && arb_lost));
  // R4
  drive_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (state == ST_BITS));
  // R2
  busy_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(len_r));
endmodule

// File: tb/sim_cec_tx_seq.sv
module sim_cec_tx_seq;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = '0;
  logic [1:0] sft_sel = '0;
  logic       stop_on_nack = 1'b0;
  logic       fol_low = 1'b0;
  logic       line_in;
  logic       wr_ready, drive_low, busy, done, ack_ok, tx_err, arb_lost;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] mem_m [16];
  bit drv_q[$];
  bit fol_q[$];

  assign line_in = !(drive_low || fol_low);

  always #2 clk = ~clk;

  cec_tx_seq #(.UNIT_DIV(DIV), .DEPTH(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .sft_sel(sft_sel), .stop_on_nack(stop_on_nack), .line_in(line_in),
    .drive_low(drive_low), .busy(busy), .done(done), .ack_ok(ack_ok),
    .tx_err(tx_err), .arb_lost(arb_lost));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = d;
    if (wr_ready) mem_m[a] = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push_bit(input int low_u, input bit pull, input int keep_u);
    for (int c = 0; c < keep_u * DIV; c++) begin
      drv_q.push_back((c / DIV) < low_u);
      fol_q.push_back(pull && ((c / DIV) < 30));
    end
  endtask

  // model of one frame; pull_byte/pull_bit: far end overrides that bit
  task automatic run_frame(input logic [7:0] ctl, input logic [1:0] sft,
                           input bit stopn, input logic [15:0] ackm,
                           input int pull_byte, input int pull_bit,
                           input int wait_low_u, input bit poke, input string tag);
    int len, need, idx;
    bit stop, ackall, e_ack, e_err, e_arb, val, pull, e;
    len = int'(ctl[4:0]);
    e_ack = 0; e_err = 0; e_arb = 0;
    drv_q.delete(); fol_q.delete();
    if (len >= 1 && len <= 16) begin
      need = (sft == 0) ? 3 : (sft == 1) ? 5 : 7;
      for (int c = 0; c < (wait_low_u + need * 48) * DIV; c++) begin
        drv_q.push_back(1'b0);
        fol_q.push_back(c < wait_low_u * DIV);
      end
      if (ctl[6]) push_bit(74, 1'b0, 90);
      stop = 0; ackall = 1;
      for (int i = 0; i < len && !stop; i++) begin
        for (int b = 0; b < 10 && !stop; b++) begin
          val  = (b < 8) ? mem_m[i][7-b] : (b == 8) ? (ctl[7] && i == len - 1) : 1'b1;
          pull = (b == 9) ? ackm[i] : (i == pull_byte && b == pull_bit);
          if (b != 9 && val && pull) begin
            push_bit(12, 1'b1, 22); stop = 1;
            if (i == 0) e_arb = 1; else e_err = 1;
          end else if (b == 9 && !pull) begin
            ackall = 0;
            if (stopn) begin push_bit(12, 1'b0, 22); stop = 1; end
            else push_bit(12, 1'b0, 48);
          end else begin
            push_bit(val ? 12 : 30, pull, 48);
          end
        end
      end
      e_ack = !stop && ackall;
    end else begin
      e_err = 1;
    end
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = ctl; sft_sel = sft; stop_on_nack = stopn;
    @(negedge clk);
    ctl_wr = 1'b0;
    idx = 0;
    while (drv_q.size() > 0) begin
      e = drv_q.pop_front();
      fol_low = fol_q.pop_front();
      check(drive_low == e, tag, "drive_low", int'(drive_low), int'(e));
      check(done == 1'b0, "R11", "done during frame", int'(done), 0);
      if (poke && idx == 100) begin
        // R1 byte offered while busy; R2 launch while busy
        wr_valid = 1'b1; wr_addr = 4'd0; wr_data = 8'hFF;
        ctl_wr = 1'b1; ctl_data = 8'h21;
        check(wr_ready == 1'b0, "R1", "wr_ready busy", int'(wr_ready), 0);
      end else begin
        wr_valid = 1'b0; ctl_wr = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    fol_low = 1'b0; wr_valid = 1'b0; ctl_wr = 1'b0;
    check(done == 1'b1, "R11", {tag, " done"}, int'(done), 1);
    check(ack_ok == e_ack, "R11", {tag, " ack_ok"}, int'(ack_ok), int'(e_ack));
    check(tx_err == e_err, "R10", {tag, " tx_err"}, int'(tx_err), int'(e_err));
    check(arb_lost == e_arb, "R9", {tag, " arb_lost"}, int'(arb_lost), int'(e_arb));
    check(drive_low == 1'b0 && busy == 1'b0, "R11", {tag, " released"},
          int'({drive_low, busy}), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(drive_low == 0 && done == 0 && busy == 0, "R11", "reset outputs",
          int'({drive_low, done, busy}), 0);
    check(wr_ready == 1 && ack_ok == 0 && tx_err == 0 && arb_lost == 0, "R1",
          "reset flags", int'({wr_ready, ack_ok, tx_err, arb_lost}), 8);

    wr_byte(0, 8'h40);
    wr_byte(1, 8'h04);
    wr_byte(2, 8'hA5);
    // R4 R5 R6 R12: start bit, data shapes, auto end-of-message, 7-period wait
    run_frame(8'hE2, 2'd2, 1'b0, 16'hFFFF, -1, -1, 0, 1'b0, "R5");
    // R8: byte 1 not acknowledged, stop requested, 5-period wait
    run_frame(8'hE3, 2'd1, 1'b1, 16'h0005, -1, -1, 0, 1'b0, "R8");
    // R7: same missing acknowledge without stop runs to the end
    run_frame(8'hE3, 2'd1, 1'b0, 16'h0005, -1, -1, 0, 1'b0, "R7");
    // R9: header bit 1 (a 1 in 0x40) overridden
    run_frame(8'hE2, 2'd2, 1'b0, 16'hFFFF, 0, 1, 0, 1'b0, "R9");
    // R10: byte 1 bit index 5 (a 1 in 0x04) overridden
    run_frame(8'hE2, 2'd2, 1'b0, 16'hFFFF, 1, 5, 0, 1'b0, "R10");
    // R2: invalid counts 0 and 17
    run_frame(8'h20, 2'd2, 1'b0, 16'hFFFF, -1, -1, 0, 1'b0, "R2");
    run_frame(8'h31, 2'd2, 1'b0, 16'hFFFF, -1, -1, 0, 1'b0, "R2");
    // R3 R4 R6: no start bit, no end-of-message, 3-period wait after 5 low units
    run_frame(8'h22, 2'd0, 1'b0, 16'hFFFF, -1, -1, 5, 1'b0, "R3");
    for (int i = 0; i < 16; i++) wr_byte(i, 8'(i * 17 + 3));
    // R1 R2: full 16-byte frame with writes and a launch offered mid-frame
    run_frame(8'hF0, 2'd2, 1'b0, 16'hFFFF, -1, -1, 0, 1'b1, "R1");
    // R1: byte 0 still holds its old value
    run_frame(8'hE1, 2'd0, 1'b0, 16'hFFFF, -1, -1, 0, 1'b0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule